// File: doc/BRIEF.md
# Burst Beat Address and Lane Mask Generator

This block takes one burst request and turns it into its beats. A request carries a start address, a length code, a beat size code and a burst kind. For each beat, the block presents the beat address, a byte-lane enable mask for the data bus and a flag that marks the final beat. A master-side write or read engine sits downstream of it. That engine uses the beat stream to place or pick up data lanes. It does not need to repeat the burst arithmetic.

The block has three states. In `ST_IDLE` it waits for a request and holds `req_ready` high. From there a valid request takes the *accept* transition to `ST_EMIT`, and a malformed request takes the *reject* transition to `ST_REJECT`. In `ST_EMIT` the block presents one beat at a time. The *advance* transition stays in `ST_EMIT` when a non-final beat is taken. The *finish* transition returns to `ST_IDLE` when the final beat is taken. `ST_REJECT` lasts one cycle, raises the error flag, and then takes the *recover* transition back to `ST_IDLE`.

The block accepts narrow beats, meaning a beat size smaller than the bus. It also accepts a start address that is not aligned to the beat size. Only the first beat of such a burst can be partial. Every later beat is aligned to its size.

Top module: `axi_beat_gen`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken in a cycle where `req_valid` and `req_ready` are both high. Right after reset the block is idle: `req_ready`=1, `beat_valid`=0 and `req_err`=0.
- R2: An accepted request produces exactly `req_len`+1 beats. `beat_last` is high on the final beat and low on every other beat.
- R3: A beat stays on the outputs, unchanged, until a cycle where `beat_valid` and `beat_ready` are both high.
- R4: Kind 0 (fixed) presents the start address on every beat.
- R5: Kind 1 (incrementing) presents the start address on the first beat. Each later address is the previous address rounded down to a multiple of 2^`req_size`, plus 2^`req_size`.
- R6: Kind 2 (wrapping) steps by 2^`req_size`. The step stays inside the window of 2^`req_size`×(`req_len`+1) bytes, aligned to its own size, that contains the start address. After the top of the window, the next address is the bottom of the window.
- R7: Lane i of `beat_mask` stands for the byte whose address modulo the bus width in bytes equals i (little-endian). Lanes are enabled from the beat address offset up to the end of the 2^`req_size`-byte container that holds that address. No other lane is enabled.
- R8: The following requests are rejected:
  - kind 3;
  - a size code above log2 of the bus width in bytes;
  - a kind 2 request whose `req_len` is not 1, 3, 7 or 15;
  - a kind 2 request whose start address is not a multiple of 2^`req_size`.

  A rejected request raises `req_err` for exactly one cycle and produces no beats.
- R9: In the cycle where the final beat is taken, `req_ready` is low. A request held on the input is accepted in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Start address |
| req_len | input | LEN_W | Beat count minus one |
| req_size | input | SIZE_W | log2 of bytes per beat |
| req_kind | input | 2 | 0 fixed, 1 incrementing, 2 wrapping, 3 reserved |
| req_err | output | 1 | One-cycle pulse for a rejected request |
| beat_valid | output | 1 | Beat present |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_addr | output | ADDR_W | Beat address |
| beat_mask | output | BUS_BYTES | Byte-lane enables |
| beat_last | output | 1 | Final beat of the burst |

## Verification
Two events can fall in the same clock edge: the final beat being taken, and a new request arriving. The bench provokes this by raising `req_valid` with a fresh request during the very cycle in which it accepts the final beat. It then judges that `req_ready` is low in that cycle, and that the request is taken one cycle later and starts its own beat sequence cleanly. The consumer's stall pattern also lands final-beat handshakes on many phases across the sweep. Each stalled cycle re-checks the beat that is being held.

// File: rtl/beat_gen_pkg.sv
package beat_gen_pkg;

    typedef enum logic [1:0] {
        BK_FIXED = 2'd0,
        BK_INCR  = 2'd1,
        BK_WRAP  = 2'd2,
        BK_RSVD  = 2'd3
    } burst_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EMIT   = 2'd1,
        ST_REJECT = 2'd2
    } gen_state_t;

endpackage

// File: rtl/beat_req_check.sv
module beat_req_check
    import beat_gen_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 8,
    parameter int SIZE_W    = 3,
    parameter int BUS_BYTES = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [SIZE_W-1:0] size,
    input  logic [1:0]        kind,
    output logic              bad
);
    localparam int LANE_LG = $clog2(BUS_BYTES);

    logic [ADDR_W-1:0] unit_low;
    logic              len_pow2;

    always_comb begin
        unit_low = (ADDR_W'(1) << size) - ADDR_W'(1);
        len_pow2 = (len == LEN_W'(1)) || (len == LEN_W'(3)) ||
                   (len == LEN_W'(7)) || (len == LEN_W'(15));
        bad = 1'b0;
        if (kind == BK_RSVD)
            bad = 1'b1;
        if (int'(size) > LANE_LG)
            bad = 1'b1;
        if (kind == BK_WRAP) begin
            if (!len_pow2)
                bad = 1'b1;
            if ((addr & unit_low) != '0)
                bad = 1'b1;
        end
    end

endmodule

// File: rtl/beat_addr_step.sv
module beat_addr_step
    import beat_gen_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int SIZE_W = 3
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [SIZE_W-1:0] size,
    input  logic [1:0]        kind,
    output logic [ADDR_W-1:0] nxt_addr
);
    logic [ADDR_W-1:0] unit;
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] win_low;

    always_comb begin
        unit    = ADDR_W'(1) << size;
        aligned = cur_addr & ~(unit - ADDR_W'(1));
        span    = unit * (ADDR_W'(len) + ADDR_W'(1));
        win_low = span - ADDR_W'(1);
        unique case (kind)
            BK_FIXED: nxt_addr = cur_addr;
            BK_WRAP:  nxt_addr = (cur_addr & ~win_low) | ((cur_addr + unit) & win_low);
            default:  nxt_addr = aligned + unit;
        endcase
    end

endmodule

// File: rtl/beat_lane_mask.sv
module beat_lane_mask #(
    parameter int SIZE_W    = 3,
    parameter int BUS_BYTES = 8,
    localparam int LANE_LG  = $clog2(BUS_BYTES)
) (
    input  logic [LANE_LG-1:0]   lane_off,
    input  logic [SIZE_W-1:0]    size,
    output logic [BUS_BYTES-1:0] mask
);
    int lo_i;
    int hi_i;

    always_comb begin
        lo_i = int'(lane_off);
        hi_i = (lo_i & ~((1 << size) - 1)) + (1 << size);
    end

    for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane
        assign mask[g] = (g >= lo_i) && (g < hi_i);
    end

endmodule

// File: rtl/axi_beat_gen.sv
module axi_beat_gen
    import beat_gen_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 8,
    parameter int SIZE_W    = 3,
    parameter int BUS_BYTES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [SIZE_W-1:0]    req_size,
    input  logic [1:0]           req_kind,
    output logic                 req_err,
    output logic                 beat_valid,
    input  logic                 beat_ready,
    output logic [ADDR_W-1:0]    beat_addr,
    output logic [BUS_BYTES-1:0] beat_mask,
    output logic                 beat_last
);
    localparam int LANE_LG = $clog2(BUS_BYTES);

    gen_state_t        state;
    gen_state_t        nxt_state;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] step_addr;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [SIZE_W-1:0] size_q;
    logic [1:0]        kind_q;
    logic              req_bad;
    logic              take_req;
    logic              take_beat;

    beat_req_check #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .BUS_BYTES(BUS_BYTES)
    ) u_check (
        .addr(req_addr), .len(req_len), .size(req_size), .kind(req_kind), .bad(req_bad)
    );

    beat_addr_step #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)
    ) u_step (
        .cur_addr(cur_addr), .len(len_q), .size(size_q), .kind(kind_q), .nxt_addr(step_addr)
    );

    beat_lane_mask #(
        .SIZE_W(SIZE_W), .BUS_BYTES(BUS_BYTES)
    ) u_mask (
        .lane_off(cur_addr[LANE_LG-1:0]), .size(size_q), .mask(beat_mask)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt_state;
    end

    // transitions
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid)
                    nxt_state = req_bad ? ST_REJECT : ST_EMIT;   // reject / accept
            end
            ST_EMIT: begin
                if (beat_ready && beat_last)
                    nxt_state = ST_IDLE;                         // finish
            end
            ST_REJECT: nxt_state = ST_IDLE;                      // recover
            default:   nxt_state = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        beat_valid = 1'b0;
        req_err    = 1'b0;
        unique case (state)
            ST_IDLE:   req_ready  = 1'b1;
            ST_EMIT:   beat_valid = 1'b1;
            ST_REJECT: req_err    = 1'b1;
            default:   ;
        endcase
        beat_addr = cur_addr;
        beat_last = (cnt_q == len_q);
    end

    assign take_req  = req_valid && req_ready && !req_bad;
    assign take_beat = beat_valid && beat_ready;

    // burst context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            len_q    <= '0;
            cnt_q    <= '0;
            size_q   <= '0;
            kind_q   <= BK_INCR;
        end else if (take_req) begin
            cur_addr <= req_addr;
            len_q    <= req_len;
            cnt_q    <= '0;
            size_q   <= req_size;
            kind_q   <= req_kind;
        end else if (take_beat && !beat_last) begin
            cur_addr <= step_addr;
            cnt_q    <= cnt_q + LEN_W'(1);
        end
    end

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid || req_err) |-> !req_ready);                                   // R1
    AST_LAST_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && beat_last) |=> !beat_valid);                  // R2
    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) && $stable(beat_mask) && $stable(beat_last))); // R3
    AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (beat_mask != '0));                                         // R7
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> (!req_err && !beat_valid));                                    // R8
    AST_NO_TAKE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && beat_last && req_valid) |=> req_ready);       // R9

endmodule

// File: tb/axi_beat_gen_tb.sv
module axi_beat_gen_tb;
    localparam int AW = 32;
    localparam int LW = 8;
    localparam int SW = 3;
    localparam int DB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [SW-1:0] req_size = '0;
    logic [1:0]    req_kind = '0;
    logic          req_err;
    logic          beat_valid;
    logic          beat_ready = 1'b0;
    logic [AW-1:0] beat_addr;
    logic [DB-1:0] beat_mask;
    logic          beat_last;

    int  n_vec = 0;
    int  n_bad = 0;
    int  stall_ph = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    axi_beat_gen #(.ADDR_W(AW), .LEN_W(LW), .SIZE_W(SW), .BUS_BYTES(DB)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_size(req_size), .req_kind(req_kind),
        .req_err(req_err), .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_addr(beat_addr), .beat_mask(beat_mask), .beat_last(beat_last)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic longint exp_addr(longint st, int sz, int ln, int kd, int n);
        longint unit = longint'(1) << sz;
        longint span = unit * (ln + 1);
        longint low;
        if (kd == 0) return st;
        if (kd == 1) return (n == 0) ? st : (st - st % unit) + n * unit;
        low = st - st % span;
        return low + ((st - low) + n * unit) % span;
    endfunction

    function automatic longint exp_mask(longint a, int sz);
        longint unit = longint'(1) << sz;
        longint m = 0;
        for (longint b = a; b < a - a % unit + unit; b++)
            m = m | (longint'(1) << (b % DB));
        return m;
    endfunction

    function automatic bit is_bad(longint a, int sz, int ln, int kd);
        if (kd == 3 || sz > 3) return 1'b1;
        if (kd == 2 && !(ln == 1 || ln == 3 || ln == 7 || ln == 15)) return 1'b1;
        if (kd == 2 && (a % (longint'(1) << sz)) != 0) return 1'b1;
        return 1'b0;
    endfunction

    // Runs one request starting at a negedge; with chain set, the next
    // request is raised during the final beat handshake.
    task automatic run_burst(input longint a, input int sz, input int ln, input int kd,
                             input bit chain, input longint na, input int nsz, input int nln, input int nkd);
        int  n = 0;
        bit  rdy;
        req_addr  = AW'(a);
        req_size  = SW'(sz);
        req_len   = LW'(ln);
        req_kind  = 2'(kd);
        req_valid = 1'b1;
        check(req_ready == 1'b1, "R1 ready in idle", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (is_bad(a, sz, ln, kd)) begin
            check(req_err == 1'b1 && beat_valid == 1'b0, "R8 error pulse", {req_err, beat_valid}, 2);
            @(negedge clk);
            check(req_err == 1'b0 && req_ready == 1'b1 && beat_valid == 1'b0, "R8 single cycle, no beats",
                  {req_err, req_ready, beat_valid}, 2);
            return;
        end
        while (n <= ln) begin
            stall_ph++;
            rdy = (stall_ph % 3) != 1;
            beat_ready = rdy;
            check(beat_valid == 1'b1, "R2 beat present", beat_valid, 1);
            check(longint'(beat_addr) == exp_addr(a, sz, ln, kd, n),
                  (kd == 0) ? "R4 fixed addr" : (kd == 1) ? "R5 incr addr" : "R6 wrap addr",
                  beat_addr, exp_addr(a, sz, ln, kd, n));
            check(longint'(beat_mask) == exp_mask(longint'(beat_addr), sz), "R7 lane mask",
                  beat_mask, exp_mask(longint'(beat_addr), sz));
            check(beat_last == (n == ln), "R2 last flag", beat_last, (n == ln));
            if (!rdy)
                check(req_ready == 1'b0, "R3 stalled beat blocks request", req_ready, 0);
            if (rdy && n == ln && chain) begin
                req_addr  = AW'(na);
                req_size  = SW'(nsz);
                req_len   = LW'(nln);
                req_kind  = 2'(nkd);
                req_valid = 1'b1;
                check(req_ready == 1'b0, "R9 no accept on final beat", req_ready, 0);
            end
            @(negedge clk);
            if (rdy) n++;
        end
        beat_ready = 1'b0;
        check(beat_valid == 1'b0 && req_ready == 1'b1, "R2 burst ends", {beat_valid, req_ready}, 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        int lens[6] = '{0, 1, 2, 3, 7, 15};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(req_ready == 1'b1 && beat_valid == 1'b0 && req_err == 1'b0, "R1 reset state",
              {req_ready, beat_valid, req_err}, 4);
        // documented wrap example: 8 four-byte beats from 0x48
        run_burst(64'h48, 2, 7, 2, 1'b0, 0, 0, 0, 0);
        // final beat collides with the next request (R9)
        run_burst(64'h103, 1, 3, 1, 1'b1, 64'h210, 2, 1, 1);
        check(req_ready == 1'b1 && beat_valid == 1'b0, "R9 accept one cycle later", {req_ready, beat_valid}, 2);
        run_burst(64'h210, 2, 1, 1, 1'b1, 64'h77, 0, 3, 0);
        run_burst(64'h77, 0, 3, 0, 1'b0, 0, 0, 0, 0);
        // sweep kinds, sizes, lengths and start offsets
        for (int kd = 0; kd < 3; kd++)
            for (int sz = 0; sz < 4; sz++)
                for (int li = 0; li < 6; li++)
                    for (int off = 0; off < 8; off++)
                        run_burst(64'h1C0 + off, sz, lens[li], kd, 1'b0, 0, 0, 0, 0);
        // reserved kind and oversize beats (R8)
        for (int sz = 0; sz < 8; sz++)
            run_burst(64'h40, sz, 3, 3, 1'b0, 0, 0, 0, 0);
        for (int sz = 4; sz < 8; sz++)
            run_burst(64'h40, sz, 1, 1, 1'b0, 0, 0, 0, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule